// File: doc/BRIEF.md
# Serial Single-Wire Bus Master

This block is the initiating end of a narrow serial request/response link to a slow peripheral address space. A parallel request port takes a read/write flag, a 2-bit size code, a 28-bit bus address and up to 64 bits of write data. The block turns the request into a frame on one outbound data line, one bit per clock.

After the frame the block stops driving the line and waits for the slave to answer on the inbound line. The answer is a start bit, data of the coded width and a parity bit. The block returns the received data, zero-extended to 64 bits, on a valid/ready completion port. The completion carries a parity-error flag and a timeout flag.

Only one request is in flight at a time. The request port stays closed from acceptance until the completion has been handed over.

Top module: `ssb_master`

## Requirements
- R1: After reset `sd_o` and `sd_oe_o` are low, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: The cycle after a request is accepted, the frame starts on `sd_o` with `sd_oe_o` high. The frame is a start bit of 1, then a 3-bit command {read, size[1], size[0]}, then the 28-bit address, each field MSB first. Read is 1 and write is 0.
- R3: On writes only, the address is followed by the low 2^(size+3) bits of `req_wdata_i`, MSB first. Size code 0 sends 8 bits, 1 sends 16, 2 sends 32 and 3 sends 64. Upper write-data bits are not sent.
- R4: The frame ends with one parity bit equal to the XOR of a constant 1, the command and the address. Write data is not included. On the next cycle `sd_oe_o` and `sd_o` are low, and `sd_o` is low whenever `sd_oe_o` is low.
- R5: Once the frame ends, the first clock edge that samples `sd_i` high takes it as a start bit. The next 2^(size+3) samples are response data, MSB first, and the sample after them is response parity. `rsp_rdata_o` carries the data zero-extended, for both reads and writes.
- R6: The expected response parity is the XOR of the response data bits. On a mismatch `rsp_perr_o` is set with the completion, and the received data is still returned.
- R7: If `sd_i` is sampled low on `tmo_limit_i` consecutive edges while waiting (a limit of 0 acts as 1), the completion is given with `rsp_timeout_o` high, `rsp_perr_o` low and zero data. A start bit on the edge that would reach the limit is still accepted.
- R8: `rsp_valid_o` and the completion fields hold until `rsp_ready_i` is high at a clock edge. `req_ready_o` is low from acceptance until that edge and high on the next cycle.
- R9: `rsp_valid_o` rises in the cycle after the edge that samples the response parity bit, or after the edge that reaches the timeout limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle, request taken on this edge |
| req_read_i | input | 1 | 1 read, 0 write |
| req_size_i | input | 2 | Size code, 2^n bytes |
| req_addr_i | input | 28 | Bus address |
| req_wdata_i | input | 64 | Write data, low bits used |
| tmo_limit_i | input | 16 | Response wait limit in cycles |
| rsp_valid_o | output | 1 | Completion available |
| rsp_ready_i | input | 1 | Completion consumed |
| rsp_rdata_o | output | 64 | Response data, zero-extended |
| rsp_perr_o | output | 1 | Response parity mismatch |
| rsp_timeout_o | output | 1 | No start bit within the limit |
| sd_o | output | 1 | Outbound serial data |
| sd_oe_o | output | 1 | Outbound line driven |
| sd_i | input | 1 | Inbound serial data |

## Verification
Requests are driven with all four size codes, for reads and for writes. Write data with nonzero upper bits shows whether the length is truncated correctly. All-ones and mixed addresses expose bit-order and parity errors in the header. Responses come after zero, short and long gaps, with good and inverted parity. This separates a correct receive window from an off-by-one, and a parity check from a data check. Gaps that equal the limit, fall one short of it, or meet a limit of 0 pin down the timeout boundary. A held completion shows that the response stays stable under backpressure.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_PAR, S_DONE} state_e;

  function automatic int size_bits(input logic [1:0] s);
    return 8 << s;
  endfunction
endpackage

// File: rtl/ssb_tx.sv
module ssb_tx #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              read_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int HDR_W   = 4 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, frame;
  logic [CNT_W-1:0]   cnt_q, dlen;
  logic [DATA_W-1:0]  data_left;
  logic               par;
  int                 shamt;

  always_comb begin
    dlen      = read_i ? '0 : CNT_W'(ssb_pkg::size_bits(size_i));
    shamt     = DATA_W - int'(dlen);
    data_left = read_i ? '0 : (wdata_i << shamt);
    par       = ^{1'b1, read_i, size_i, addr_i};
    frame     = {1'b1, read_i, size_i, addr_i, data_left, 1'b0}
              | (FRAME_W'(par) << shamt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame;
      cnt_q <= CNT_W'(HDR_W + 1) + dlen;
    end else if (shift_i) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[FRAME_W-1];
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ssb_rx.sv
module ssb_rx #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      par_o  <= 1'b0;
    end else if (clr_i) begin
      data_o <= '0;
      par_o  <= 1'b0;
    end else if (shift_i) begin
      data_o <= {data_o[DATA_W-2:0], bit_i};
      par_o  <= par_o ^ bit_i;
    end
  end
endmodule

// File: rtl/ssb_master.sv
module ssb_master #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64,
  parameter int TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_read_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_perr_o,
  output logic              rsp_timeout_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  import ssb_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 1);

  state_e           state_q;
  logic [1:0]       size_q;
  logic [CNT_W-1:0] rx_cnt_q;
  logic [TMO_W-1:0] wait_cnt_q;
  logic [TMO_W:0]   wait_nxt;
  logic             perr_q, tmo_q;
  logic             accept, tx_bit, tx_last, rx_par;
  logic [DATA_W-1:0] rx_data;

  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign wait_nxt = {1'b0, wait_cnt_q} + 1'b1;

  ssb_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i  (accept),
    .shift_i (state_q == S_SEND),
    .read_i  (req_read_i),
    .size_i  (req_size_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .bit_o   (tx_bit),
    .last_o  (tx_last)
  );

  ssb_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .clr_i   (accept),
    .shift_i (state_q == S_RECV),
    .bit_i   (sd_i),
    .data_o  (rx_data),
    .par_o   (rx_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      size_q     <= '0;
      rx_cnt_q   <= '0;
      wait_cnt_q <= '0;
      perr_q     <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          size_q  <= req_size_i;
          perr_q  <= 1'b0;
          tmo_q   <= 1'b0;
          state_q <= S_SEND;
        end
        S_SEND: if (tx_last) begin
          wait_cnt_q <= '0;
          state_q    <= S_WAIT;
        end
        S_WAIT: begin
          if (sd_i) begin
            rx_cnt_q <= CNT_W'(size_bits(size_q));
            state_q  <= S_RECV;
          end else if (wait_nxt >= {1'b0, tmo_limit_i}) begin
            tmo_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            wait_cnt_q <= wait_nxt[TMO_W-1:0];
          end
        end
        S_RECV: begin
          rx_cnt_q <= rx_cnt_q - 1'b1;
          if (rx_cnt_q == CNT_W'(1)) state_q <= S_PAR;
        end
        S_PAR: begin
          perr_q  <= sd_i ^ rx_par;
          state_q <= S_DONE;
        end
        S_DONE: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign rsp_valid_o   = (state_q == S_DONE);
  assign rsp_rdata_o   = rx_data;
  assign rsp_perr_o    = perr_q;
  assign rsp_timeout_o = tmo_q;
  assign sd_oe_o       = (state_q == S_SEND);
  assign sd_o          = sd_oe_o && tx_bit;
endmodule

// File: rtl/ssb_master_chk.sv
module ssb_master_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_perr_o,
  input logic              rsp_timeout_o,
  input logic              sd_o,
  input logic              sd_oe_o
);
  p_line_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o |-> !sd_o);

  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> sd_oe_o && sd_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o)
      && $stable(rsp_perr_o) && $stable(rsp_timeout_o));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  p_tmo_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_timeout_o |-> rsp_rdata_o == '0 && !rsp_perr_o);

  p_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !sd_oe_o);
endmodule

bind ssb_master ssb_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .rsp_valid_o, .rsp_ready_i,
  .rsp_rdata_o, .rsp_perr_o, .rsp_timeout_o, .sd_o, .sd_oe_o
);

// File: tb/sim_ssb_master.sv
module sim_ssb_master;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, rsp_ready = 1'b0, sd_in = 1'b0;
  logic [1:0]  req_size = '0;
  logic [27:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [15:0] tmo_limit = 16'd20;
  logic        req_ready, rsp_valid, rsp_perr, rsp_timeout, sd_out, sd_oe;
  logic [63:0] rsp_rdata;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ssb_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_read_i(req_read), .req_size_i(req_size), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .tmo_limit_i(tmo_limit), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .rsp_perr_o(rsp_perr),
    .rsp_timeout_o(rsp_timeout), .sd_o(sd_out), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic run_txn(input bit rd, input bit [1:0] sz, input bit [27:0] ad,
                         input bit [63:0] wd, input bit [63:0] resp, input int dly,
                         input bit badp, input int hold);
    int w = 8 << sz;
    int lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
    bit q[$];
    bit p;
    int bad = 0;
    int first_bad = -1;
    bit [63:0] expd;
    bit [63:0] snap;
    q.push_back(1'b1); q.push_back(rd); q.push_back(sz[1]); q.push_back(sz[0]);
    p = 1'b1 ^ rd ^ sz[1] ^ sz[0];
    for (int i = 27; i >= 0; i--) begin q.push_back(ad[i]); p ^= ad[i]; end
    if (!rd) for (int i = w - 1; i >= 0; i--) q.push_back(wd[i]);
    q.push_back(p);

    @(negedge clk);
    check(req_ready === 1'b1, "R8 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_read = rd; req_size = sz; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wd;
    foreach (q[i]) begin
      if (sd_oe !== 1'b1 || sd_out !== q[i] || req_ready !== 1'b0) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      @(negedge clk);
    end
    check(bad == 0, "R2 R3 R4 R9 frame bits (mismatches, first index)", 64'(bad), 64'(first_bad));
    check(sd_oe === 1'b0 && sd_out === 1'b0, "R4 line released", {sd_oe, sd_out}, 64'd0);

    if (dly >= lim) begin
      repeat (lim - 1) @(negedge clk);
      check(rsp_valid === 1'b0, "R7 no early timeout", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_timeout === 1'b1 && rsp_perr === 1'b0,
            "R7 timeout completion", {rsp_valid, rsp_timeout, rsp_perr}, 64'b110);
      check(rsp_rdata === 64'd0, "R7 timeout data zero", rsp_rdata, 64'd0);
    end else begin
      repeat (dly) @(negedge clk);
      sd_in = 1'b1;
      @(negedge clk);
      for (int i = w - 1; i >= 0; i--) begin sd_in = resp[i]; @(negedge clk); end
      p = 1'b0;
      for (int i = 0; i < w; i++) p ^= resp[i];
      sd_in = p ^ badp;
      @(negedge clk);
      sd_in = 1'b0;
      expd = (w == 64) ? resp : (resp & ((64'd1 << w) - 1));
      check(rsp_valid === 1'b1 && rsp_timeout === 1'b0, "R9 R5 completion after parity",
            {rsp_valid, rsp_timeout}, 64'b10);
      check(rsp_rdata === expd, "R5 response data", rsp_rdata, expd);
      check(rsp_perr === badp, "R6 parity flag", 64'(rsp_perr), 64'(badp));
    end

    snap = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_rdata === snap,
            "R8 held under backpressure", rsp_rdata, snap);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 released after handshake",
          {rsp_valid, req_ready}, 64'b01);
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sd_out === 1'b0 && sd_oe === 1'b0 && req_ready === 1'b1 && rsp_valid === 1'b0,
          "R1 reset state", {sd_out, sd_oe, req_ready, rsp_valid}, 64'b0010);
    rst_ni = 1'b1;
    @(negedge clk);
    check(sd_out === 1'b0 && sd_oe === 1'b0 && req_ready === 1'b1, "R1 idle after reset",
          {sd_out, sd_oe, req_ready}, 64'b001);

    run_txn(1'b1, 2'd0, 28'hABCDE12, 64'h0, 64'h5A, 3, 1'b0, 0);
    run_txn(1'b0, 2'd3, 28'h0123456, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0, 1'b0, 0);
    run_txn(1'b0, 2'd0, 28'h5555555, 64'hFFFF_FFFF_FFFF_FF3C, 64'hC3, 1, 1'b0, 0);
    run_txn(1'b0, 2'd1, 28'hFFFFFFF, 64'hAAAA_AAAA_AAAA_1234, 64'hBEEF, 2, 1'b0, 1);
    run_txn(1'b1, 2'd2, 28'h0000001, 64'h0, 64'hDEAD_BEEF, 5, 1'b1, 0);
    tmo_limit = 16'd5;
    run_txn(1'b1, 2'd1, 28'h1234567, 64'h0, 64'h0, 10, 1'b0, 2);
    run_txn(1'b1, 2'd3, 28'h7654321, 64'h0, 64'h8000_0000_0000_0001, 4, 1'b0, 3);
    run_txn(1'b1, 2'd0, 28'h0F0F0F0, 64'h0, 64'h0, 5, 1'b0, 0);
    tmo_limit = 16'd0;
    run_txn(1'b0, 2'd2, 28'h00000AA, 64'h1111_2222_3333_4444, 64'h0, 1, 1'b0, 0);
    run_txn(1'b1, 2'd0, 28'h3333333, 64'h0, 64'h7F, 0, 1'b1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule